// File: doc/BRIEF.md
# Address-Dependent Bus Cycle Length Timer

This block sets how many master clocks each processor bus cycle lasts, and it gives the processor one clock-enable pulse for each cycle. At the start of every cycle it reads the 24-bit bus address, a flag that tells a memory access apart from an internal operation, and a fast-ROM enable. From these it picks a length of 6, 8 or 12 master clocks. It counts that many clocks and raises a one-clock `cycle_end` strobe on the last one. The processor core uses this strobe as its clock enable.

The address decoder resolves only the regions that change timing. These are work RAM, general I/O registers, the two serial controller-port registers, and everything else, which counts as ROM. The length is fixed at the start of a cycle. A `hold` input stops the count without losing its place, so a refresh stall can stretch the current cycle.

Top module: `bus_cycle_timer`

## Requirements
- R1: When `mem_access` is 0 (internal operation), the cycle lasts 6 clocks and `speed_code` is 0, whatever the address.
- R2: Any access to banks $7E or $7F lasts 8 clocks with `speed_code` 1.
- R3: Offsets $0000 to $1FFF in banks $00 to $3F and $80 to $BF are work RAM: 8 clocks, `speed_code` 1.
- R4: Offsets $2000 to $5FFF in those same banks are I/O: 6 clocks, `speed_code` 0, except for the addresses in R5.
- R5: Offsets $4016 and $4017 in those same banks last 12 clocks with `speed_code` 2.
- R6: Any other address, treated as ROM, lasts 6 clocks with `speed_code` 0 when address bit 23 is 1 and `fast_rom_en` is 1.
- R7: A ROM-class access that does not meet R6 lasts 8 clocks with `speed_code` 1.
- R8: `cycle_end` is high for exactly one clock, on the last master clock of the cycle. The next cycle starts on the following clock with no gap.
- R9: The length and `speed_code` are fixed at the start of the cycle. An address change later in the cycle changes neither.
- R10: Each clock with `hold` high adds one clock to the current cycle. `cycle_end` stays low while `hold` is high.
- R11: Synchronous reset clears the count and keeps `cycle_end` low. After reset is released, a fresh cycle starts on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 24 | Bus address, sampled on the first clock of a cycle |
| mem_access | input | 1 | 1 = memory access, 0 = internal operation |
| fast_rom_en | input | 1 | Enables the short length for upper-half ROM |
| hold | input | 1 | Freezes the master-clock count |
| cycle_end | output | 1 | One-clock strobe on the last clock of a cycle |
| speed_code | output | 2 | 0 = 6 clocks, 1 = 8 clocks, 2 = 12 clocks |

## Verification
The bench targets the edges between regions:

- **Offset boundaries.** It tests $1FFF against $2000 and $5FFF against $6000. A decoder with an off-by-one boundary would give 6 instead of 8, or 8 instead of 6.
- **Serial-port addresses.** It tests $4016 and $4017 against $4018, and also $4016 in a ROM-only bank. A loose match would stretch the wrong accesses to 12 clocks.
- **Fast-ROM gating.** It covers both values of address bit 23 with the enable on and off. It also issues an internal operation at a ROM or port address, so a design that forgets `mem_access` would return the wrong length.
- **Timing corner cases.** Separate tests switch the address to a slow port mid-cycle, insert hold clocks, and reset partway through a long cycle. A design that re-decodes live, drops held clocks or keeps a stale count would end early or late.

// File: rtl/cyc_stretch_pkg.sv
package cyc_stretch_pkg;

    localparam int ADDR_W = 24;

    // Speed codes seen on the speed_code port
    typedef enum logic [1:0] {
        SPD_6  = 2'd0,
        SPD_8  = 2'd1,
        SPD_12 = 2'd2
    } speed_e;

    // Timing classes of the address map
    typedef enum logic [1:0] {
        RGN_ROM    = 2'd0,
        RGN_WRAM   = 2'd1,
        RGN_IO     = 2'd2,
        RGN_SERIAL = 2'd3
    } region_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              mem;
        logic              fast_en;
    } cyc_req_t;

    // Region boundaries within a system bank
    localparam logic [15:0] LOW_WRAM_END = 16'h2000;
    localparam logic [15:0] IO_END       = 16'h6000;
    localparam logic [15:0] SERIAL_PAIR  = 16'h4016;
    localparam logic [7:0]  WRAM_BANK_HI = 8'h7F;

    function automatic int speed_clocks(speed_e s, int fast_n, int slow_n, int xslow_n);
        case (s)
            SPD_6:   return fast_n;
            SPD_8:   return slow_n;
            default: return xslow_n;
        endcase
    endfunction

endpackage

// File: rtl/addr_region_decode.sv
module addr_region_decode
    import cyc_stretch_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output region_e       region
);
    localparam int BANK_LSB = AW - 8;

    logic [7:0]  bank;
    logic [15:0] off;
    logic        system_bank;
    logic        wram_bank;
    logic        serial_hit;

    assign bank        = addr[AW-1:BANK_LSB];
    assign off         = addr[15:0];
    assign system_bank = (bank & 8'h40) == 8'h00;
    assign wram_bank   = (bank | 8'h01) == WRAM_BANK_HI;
    assign serial_hit  = (off | 16'h0001) == (SERIAL_PAIR | 16'h0001);

    always_comb begin
        region = RGN_ROM;
        if (wram_bank) begin
            region = RGN_WRAM;
        end else if (system_bank) begin
            if (off < LOW_WRAM_END) begin
                region = RGN_WRAM;
            end else if (off < IO_END) begin
                region = serial_hit ? RGN_SERIAL : RGN_IO;
            end
        end
    end
endmodule

// File: rtl/speed_select.sv
module speed_select
    import cyc_stretch_pkg::*;
(
    input  region_e region,
    input  logic    mem,
    input  logic    upper_half,
    input  logic    fast_en,
    output speed_e  speed
);
    always_comb begin
        if (!mem) begin
            speed = SPD_6;
        end else begin
            case (region)
                RGN_WRAM:   speed = SPD_8;
                RGN_IO:     speed = SPD_6;
                RGN_SERIAL: speed = SPD_12;
                default:    speed = (upper_half && fast_en) ? SPD_6 : SPD_8;
            endcase
        end
    end
endmodule

// File: rtl/phase_counter.sv
module phase_counter
    import cyc_stretch_pkg::*;
#(
    parameter int FAST_CLKS  = 6,
    parameter int SLOW_CLKS  = 8,
    parameter int XSLOW_CLKS = 12
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   hold,
    input  speed_e live_speed,
    output speed_e eff_speed,
    output logic   cycle_end
);
    localparam int CNT_W = $clog2(XSLOW_CLKS);

    logic [CNT_W-1:0] phase;
    speed_e           held_speed;
    logic             at_start;
    logic             at_last;
    int               cur_len;

    assign at_start  = (phase == '0);
    assign eff_speed = at_start ? live_speed : held_speed;
    assign cur_len   = speed_clocks(eff_speed, FAST_CLKS, SLOW_CLKS, XSLOW_CLKS);
    assign at_last   = (int'(phase) == cur_len - 1);
    assign cycle_end = at_last && !hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= '0;
            held_speed <= SPD_6;
        end else if (!hold) begin
            if (at_last) begin
                phase <= '0;
            end else begin
                phase <= phase + 1'b1;
                if (at_start) begin
                    held_speed <= live_speed;
                end
            end
        end
    end
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
    import cyc_stretch_pkg::*;
#(
    parameter int FAST_CLKS  = 6,
    parameter int SLOW_CLKS  = 8,
    parameter int XSLOW_CLKS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_access,
    input  logic              fast_rom_en,
    input  logic              hold,
    output logic              cycle_end,
    output logic [1:0]        speed_code
);
    cyc_req_t req;
    region_e  region;
    speed_e   live_speed;
    speed_e   eff_speed;

    assign req = '{addr: addr, mem: mem_access, fast_en: fast_rom_en};

    addr_region_decode #(.AW(ADDR_W)) u_decode (
        .addr   (req.addr),
        .region (region)
    );

    speed_select u_select (
        .region     (region),
        .mem        (req.mem),
        .upper_half (req.addr[ADDR_W-1]),
        .fast_en    (req.fast_en),
        .speed      (live_speed)
    );

    phase_counter #(
        .FAST_CLKS  (FAST_CLKS),
        .SLOW_CLKS  (SLOW_CLKS),
        .XSLOW_CLKS (XSLOW_CLKS)
    ) u_count (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .live_speed (live_speed),
        .eff_speed  (eff_speed),
        .cycle_end  (cycle_end)
    );

    assign speed_code = eff_speed;
endmodule

// File: rtl/bus_cycle_timer_chk.sv
module bus_cycle_timer_chk
    import cyc_stretch_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              mem_access,
    input logic              hold,
    input logic              cycle_end,
    input logic [1:0]        speed_code
);
    logic [3:0] n_clk;
    logic       sys_bank;
    logic       port_addr;

    assign sys_bank  = (addr[ADDR_W-1:ADDR_W-8] & 8'h40) == 8'h00;
    assign port_addr = (addr[15:0] | 16'h0001) == 16'h4017;

    always_ff @(posedge clk) begin
        if (rst)            n_clk <= '0;
        else if (!hold)     n_clk <= cycle_end ? 4'd0 : n_clk + 4'd1;
    end

    AST_END_AT_LEN: assert property (@(posedge clk) disable iff (rst)
        cycle_end |-> (int'(n_clk) == speed_clocks(speed_e'(speed_code), 6, 8, 12) - 1)); // R8
    AST_END_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        cycle_end |=> !cycle_end); // R8
    AST_HOLD_NO_END: assert property (@(posedge clk) disable iff (rst)
        hold |-> !cycle_end); // R10
    AST_CODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (n_clk != 4'd0) |-> $stable(speed_code)); // R9
    AST_INTERNAL_FAST: assert property (@(posedge clk) disable iff (rst)
        (n_clk == 4'd0 && !mem_access) |-> speed_code == 2'd0); // R1
    AST_PORT_SLOW: assert property (@(posedge clk) disable iff (rst)
        (n_clk == 4'd0 && mem_access && sys_bank && port_addr) |-> speed_code == 2'd2); // R5
endmodule

bind bus_cycle_timer bus_cycle_timer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .mem_access (mem_access),
    .hold       (hold),
    .cycle_end  (cycle_end),
    .speed_code (speed_code)
);

// File: tb/bus_cycle_timer_bench.sv
`timescale 1ns/1ps
module bus_cycle_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] addr = 24'h0;
    logic        mem_access = 1'b0;
    logic        fast_rom_en = 1'b0;
    logic        hold = 1'b0;
    logic        cycle_end;
    logic [1:0]  speed_code;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bus_cycle_timer u_bus_cycle_timer (
        .clk(clk), .rst(rst), .addr(addr), .mem_access(mem_access),
        .fast_rom_en(fast_rom_en), .hold(hold),
        .cycle_end(cycle_end), .speed_code(speed_code)
    );

    typedef struct packed {
        logic [23:0] a;
        logic        m;
        logic        f;
        logic [3:0]  len;
        logic [1:0]  code;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{24'h008000, 1'b0, 1'b1, 4'd6,  2'd0, 4'd1},  // R1 internal at ROM address
        '{24'h004016, 1'b0, 1'b1, 4'd6,  2'd0, 4'd1},  // R1 internal at port address
        '{24'h7E1234, 1'b1, 1'b1, 4'd8,  2'd1, 4'd2},  // R2
        '{24'h7FFFFF, 1'b1, 1'b0, 4'd8,  2'd1, 4'd2},  // R2
        '{24'h7F8000, 1'b1, 1'b1, 4'd8,  2'd1, 4'd2},  // R2 upper offsets still RAM
        '{24'h000000, 1'b1, 1'b0, 4'd8,  2'd1, 4'd3},  // R3
        '{24'h801FFF, 1'b1, 1'b1, 4'd8,  2'd1, 4'd3},  // R3 edge
        '{24'h3F2100, 1'b1, 1'b0, 4'd6,  2'd0, 4'd4},  // R4
        '{24'h002000, 1'b1, 1'b0, 4'd6,  2'd0, 4'd4},  // R4 lower edge
        '{24'h005FFF, 1'b1, 1'b0, 4'd6,  2'd0, 4'd4},  // R4 upper edge
        '{24'h804200, 1'b1, 1'b0, 4'd6,  2'd0, 4'd4},  // R4 high mirror
        '{24'h004018, 1'b1, 1'b0, 4'd6,  2'd0, 4'd4},  // R4 next to ports
        '{24'h004015, 1'b1, 1'b0, 4'd6,  2'd0, 4'd4},  // R4 below ports
        '{24'h004016, 1'b1, 1'b0, 4'd12, 2'd2, 4'd5},  // R5
        '{24'hBF4017, 1'b1, 1'b1, 4'd12, 2'd2, 4'd5},  // R5
        '{24'h808000, 1'b1, 1'b1, 4'd6,  2'd0, 4'd6},  // R6
        '{24'hFFFFFF, 1'b1, 1'b1, 4'd6,  2'd0, 4'd6},  // R6
        '{24'hC04016, 1'b1, 1'b1, 4'd6,  2'd0, 4'd6},  // R6 port offset in ROM bank
        '{24'h806000, 1'b1, 1'b1, 4'd6,  2'd0, 4'd6},  // R6
        '{24'h404016, 1'b1, 1'b1, 4'd8,  2'd1, 4'd7},  // R7 low ROM bank
        '{24'h808000, 1'b1, 1'b0, 4'd8,  2'd1, 4'd7},  // R7 fast disabled
        '{24'h006000, 1'b1, 1'b1, 4'd8,  2'd1, 4'd7},  // R7
        '{24'h008000, 1'b1, 1'b1, 4'd8,  2'd1, 4'd7}   // R7 bit 23 clear
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called at a negedge inside the first clock of a cycle; returns at the
    // negedge inside the first clock of the following cycle.
    task automatic run_cycle(input logic [23:0] a, input logic m, input logic f,
                             input int hold_at, input int hold_len,
                             input int chg_at, input logic [23:0] chg_a,
                             output int len, output int code,
                             output int stable, output int hold_ends);
        int n = 1;
        stable = 1;
        hold_ends = 0;
        code = 0;
        mem_access = m;
        fast_rom_en = f;
        forever begin
            addr = (chg_at > 0 && n >= chg_at) ? chg_a : a;
            hold = (n >= hold_at && n < hold_at + hold_len);
            #1;
            if (n == 1) code = int'(speed_code);
            else if (int'(speed_code) != code) stable = 0;
            if (hold && cycle_end) hold_ends++;
            if (cycle_end || n > 40) break;
            @(negedge clk);
            n++;
        end
        len = n;
        hold = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int len, code, st, he;
        repeat (3) @(negedge clk);
        check("R11", "cycle_end in reset", int'(cycle_end), 0);
        rst = 1'b0;

        // R11: first cycle after reset starts at once
        run_cycle(24'h7E0000, 1'b1, 1'b0, 0, 0, 0, 24'h0, len, code, st, he);
        check("R11", "first cycle length", len, 8);

        // Table walk: R1..R7 lengths and codes, R8 strobe placement
        for (int i = 0; i < NV; i++) begin
            run_cycle(VECS[i].a, VECS[i].m, VECS[i].f, 0, 0, 0, 24'h0, len, code, st, he);
            check($sformatf("R%0d", VECS[i].req), $sformatf("length @%06h", VECS[i].a),
                  len, int'(VECS[i].len));
            check($sformatf("R%0d", VECS[i].req), $sformatf("code @%06h", VECS[i].a),
                  code, int'(VECS[i].code));
        end

        // R9: switch to a port address in clock 2; length stays 6
        run_cycle(24'h002100, 1'b1, 1'b0, 0, 0, 2, 24'h004016, len, code, st, he);
        check("R9", "length after addr change", len, 6);
        check("R9", "code stable", st, 1);
        // R9: switch from slow port to fast I/O mid-cycle
        run_cycle(24'h004017, 1'b1, 1'b0, 0, 0, 3, 24'h002100, len, code, st, he);
        check("R9", "length after addr change", len, 12);
        check("R9", "code stable", st, 1);

        // R10: three held clocks in the middle of an 8-clock cycle
        run_cycle(24'h000100, 1'b1, 1'b0, 4, 3, 0, 24'h0, len, code, st, he);
        check("R10", "held length", len, 11);
        check("R10", "no end while held", he, 0);
        // R10: hold across the would-be last clock of a 6-clock cycle
        run_cycle(24'h002200, 1'b1, 1'b0, 6, 2, 0, 24'h0, len, code, st, he);
        check("R10", "held at last clock", len, 8);
        check("R10", "no end while held", he, 0);
        // R10: hold on the first clock
        run_cycle(24'h004016, 1'b1, 1'b0, 1, 1, 0, 24'h0, len, code, st, he);
        check("R10", "held at first clock", len, 13);

        // R8: back-to-back cycles of different lengths
        run_cycle(24'h808000, 1'b1, 1'b1, 0, 0, 0, 24'h0, len, code, st, he);
        check("R8", "first of pair", len, 6);
        run_cycle(24'h004017, 1'b1, 1'b1, 0, 0, 0, 24'h0, len, code, st, he);
        check("R8", "second of pair", len, 12);

        // R11: reset partway through a 12-clock cycle
        addr = 24'h004016; mem_access = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1 check("R11", "cycle_end in reset", int'(cycle_end), 0);
        @(negedge clk);
        rst = 1'b0;
        run_cycle(24'h002300, 1'b1, 1'b0, 0, 0, 0, 24'h0, len, code, st, he);
        check("R11", "fresh cycle after reset", len, 6);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule